// File: doc/BRIEF.md
# Extend-Arithmetic Sequencer

This controller accepts one 16-bit opcode at a time and carries out add-with-extend, subtract-with-extend and negate-with-extend operations. The arithmetic and the condition flags are not computed here. Instead, the controller collects the two operands and hands them to a separate flag unit through a start/done pair. It then writes the returned result back to a data register or to memory.

The register form works between two data registers. For byte and word sizes it replaces only the low 8 or 16 bits of the destination. The memory form always runs the same sequence:

- Lower the source address register by the operand byte count.
- Read the source operand.
- Lower the destination address register by the byte count.
- Read the destination operand.
- Run the flag unit.
- Store the result at the lowered destination address.

The register file sits outside the block. The controller reaches it through two combinational read ports and one write port. A register select is 4 bits wide: bit 3 set means an address register, and bits 2:0 give the index. Memory uses a request/acknowledge port in which an access completes in the cycle where both are high.

Top module: `xarith_seq`

## Requirements
- R1: An opcode whose bits under mask 0xF138 equal 0xD100 or 0x9100 is a register-form add or subtract. Equal to 0xD108 or 0x9108, it is the memory form. The source index is bits 2:0, the destination index is bits 11:9, and the size is bits 7:6 (00 byte, 01 word, 10 long).
- R2: An accepted opcode with size 11, or one that matches no form, raises `illegal` for exactly the next cycle. It writes no register, makes no memory access and leaves the block ready.
- R3: In the memory form, the source address register is first written with its value minus 1, 2 or 4. The source is then read at that new address.
- R4: Next, the destination address register is written with its value minus the byte count. The destination is read at that address, and the result is later stored to the same address.
- R5: When both register fields of a memory-form opcode name the same address register, that register is lowered twice. The destination read then comes from the address one operand size below the source read.
- R6: The register form writes the destination data register with the result in the low 8, 16 or 32 bits and the old upper bits kept.
- R7: The pattern 0x4000 under mask 0xFF00, with bits 5:3 equal to 000, is negate-with-extend on the data register in bits 2:0. It uses that register as the source and 0 as the destination operand, and it writes the result back to the same register. Any other value in bits 5:3 is treated as under R2.
- R8: `fu_start` is a single-cycle pulse. While it is high, `fu_src` and `fu_dst` hold the operands zero-extended from the operand size, and `fu_sub` is 1 for subtract and negate. The controller waits for `fu_done` before writing.
- R9: A memory request, once raised, keeps its address, direction and size until `mem_ack` is seen.
- R10: The end of every legal operation is marked by a single-cycle `op_done` pulse, and `op_ready` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode offered |
| op_code | input | 16 | Opcode |
| op_ready | output | 1 | Idle and able to accept |
| op_done | output | 1 | Operation finished pulse |
| illegal | output | 1 | Rejected opcode pulse |
| rf_a_sel | output | 4 | Read port A select |
| rf_a_data | input | DW | Read port A data |
| rf_b_sel | output | 4 | Read port B select |
| rf_b_data | input | DW | Read port B data |
| rf_we | output | 1 | Register write enable |
| rf_wsel | output | 4 | Register write select |
| rf_wdata | output | DW | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access size, same code as opcode size |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Load data |
| mem_ack | input | 1 | Access completes this cycle |
| fu_start | output | 1 | Flag unit start pulse |
| fu_sub | output | 1 | Subtract (1) or add (0) |
| fu_size | output | 2 | Operand size |
| fu_src | output | DW | Source operand |
| fu_dst | output | DW | Destination operand |
| fu_done | input | 1 | Flag unit result valid |
| fu_result | input | DW | Flag unit result |

## Verification
Two events can share a cycle: the `illegal` pulse for a rejected opcode and the acceptance of the next opcode. This happens because rejection leaves the controller idle. The bench provokes it by holding `op_valid` high across an illegal opcode and a legal one on consecutive edges. It then judges that `illegal` is high for exactly that one cycle, that the second opcode is taken in the same cycle, and that the scoreboard sees only the second operation's register writes, memory accesses and flag-unit start, in order and with correct values.

// File: rtl/xarith_seq.sv
module xarith_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [15:0]   op_code,
  output logic          op_ready,
  output logic          op_done,
  output logic          illegal,
  output logic [3:0]    rf_a_sel,
  input  logic [DW-1:0] rf_a_data,
  output logic [3:0]    rf_b_sel,
  input  logic [DW-1:0] rf_b_data,
  output logic          rf_we,
  output logic [3:0]    rf_wsel,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          fu_start,
  output logic          fu_sub,
  output logic [1:0]    fu_size,
  output logic [DW-1:0] fu_src,
  output logic [DW-1:0] fu_dst,
  input  logic          fu_done,
  input  logic [DW-1:0] fu_result
);

  typedef enum logic [2:0] {
    S_IDLE, S_DEC_SRC, S_READ_SRC, S_DEC_DST, S_READ_DST, S_EXEC, S_WRITE, S_DONE
  } st_t;

  function automatic logic [DW-1:0] szmask(input logic [1:0] s);
    case (s)
      2'b00:   szmask = {{(DW-8){1'b0}}, 8'hFF};
      2'b01:   szmask = {{(DW-16){1'b0}}, 16'hFFFF};
      default: szmask = '1;
    endcase
  endfunction

  st_t           state;
  logic          mem_q, sub_q, neg_q, fu_start_q, illegal_q;
  logic [1:0]    sz_q;
  logic [2:0]    src_q, dst_q;
  logic [DW-1:0] opa_q, opb_q, res_q;
  logic [AW-1:0] sadr_q, dadr_q;

  wire [15:0] m1     = op_code & 16'hF138;
  wire is_add_r      = (m1 == 16'hD100);
  wire is_add_m      = (m1 == 16'hD108);
  wire is_sub_r      = (m1 == 16'h9100);
  wire is_sub_m      = (m1 == 16'h9108);
  wire is_neg        = (op_code[15:8] == 8'h40) && (op_code[5:3] == 3'b000);
  wire size_bad      = (op_code[7:6] == 2'b11);
  wire dec_ok        = (is_add_r | is_add_m | is_sub_r | is_sub_m | is_neg) & ~size_bad;
  wire dec_mem       = is_add_m | is_sub_m;
  wire accept        = op_valid && (state == S_IDLE);
  wire [DW-1:0] imask = szmask(op_code[7:6]);
  wire [DW-1:0] qmask = szmask(sz_q);

  wire [AW-1:0] step = (sz_q == 2'b00) ? AW'(1) : (sz_q == 2'b01) ? AW'(2) : AW'(4);
  wire [AW-1:0] lowered = rf_a_data[AW-1:0] - step;

  assign op_ready  = (state == S_IDLE);
  assign op_done   = (state == S_DONE);
  assign illegal   = illegal_q;

  always_comb begin
    case (state)
      S_IDLE:    rf_a_sel = {1'b0, op_code[2:0]};
      S_DEC_SRC: rf_a_sel = {1'b1, src_q};
      S_DEC_DST: rf_a_sel = {1'b1, dst_q};
      default:   rf_a_sel = {1'b0, src_q};
    endcase
  end

  assign rf_b_sel = (state == S_IDLE) ? {1'b0, (is_neg ? op_code[2:0] : op_code[11:9])}
                                      : {1'b0, dst_q};

  assign rf_we   = (state == S_DEC_SRC) || (state == S_DEC_DST) || (state == S_WRITE && !mem_q);
  always_comb begin
    case (state)
      S_DEC_SRC: begin rf_wsel = {1'b1, src_q}; rf_wdata = DW'(lowered); end
      S_DEC_DST: begin rf_wsel = {1'b1, dst_q}; rf_wdata = DW'(lowered); end
      default:   begin
        rf_wsel  = {1'b0, dst_q};
        rf_wdata = (rf_b_data & ~qmask) | (res_q & qmask);
      end
    endcase
  end

  assign mem_req   = (state == S_READ_SRC) || (state == S_READ_DST) || (state == S_WRITE && mem_q);
  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = (state == S_READ_SRC) ? sadr_q : dadr_q;
  assign mem_size  = sz_q;
  assign mem_wdata = res_q;

  assign fu_start = fu_start_q;
  assign fu_sub   = sub_q | neg_q;
  assign fu_size  = sz_q;
  assign fu_src   = opa_q;
  assign fu_dst   = opb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      mem_q      <= 1'b0;
      sub_q      <= 1'b0;
      neg_q      <= 1'b0;
      fu_start_q <= 1'b0;
      illegal_q  <= 1'b0;
      sz_q       <= 2'b00;
      src_q      <= '0;
      dst_q      <= '0;
      opa_q      <= '0;
      opb_q      <= '0;
      res_q      <= '0;
      sadr_q     <= '0;
      dadr_q     <= '0;
    end else begin
      fu_start_q <= 1'b0;
      illegal_q  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (!dec_ok) begin
            illegal_q <= 1'b1;
          end else begin
            mem_q <= dec_mem;
            sub_q <= is_sub_r | is_sub_m;
            neg_q <= is_neg;
            sz_q  <= op_code[7:6];
            src_q <= op_code[2:0];
            dst_q <= is_neg ? op_code[2:0] : op_code[11:9];
            if (dec_mem) begin
              state <= S_DEC_SRC;
            end else begin
              opa_q      <= rf_a_data & imask;
              opb_q      <= is_neg ? '0 : (rf_b_data & imask);
              fu_start_q <= 1'b1;
              state      <= S_EXEC;
            end
          end
        end
        S_DEC_SRC: begin
          sadr_q <= lowered;
          state  <= S_READ_SRC;
        end
        S_READ_SRC: if (mem_ack) begin
          opa_q <= mem_rdata & qmask;
          state <= S_DEC_DST;
        end
        S_DEC_DST: begin
          dadr_q <= lowered;
          state  <= S_READ_DST;
        end
        S_READ_DST: if (mem_ack) begin
          opb_q      <= mem_rdata & qmask;
          fu_start_q <= 1'b1;
          state      <= S_EXEC;
        end
        S_EXEC: if (fu_done) begin
          res_q <= fu_result & qmask;
          state <= S_WRITE;
        end
        S_WRITE: if (!mem_q || mem_ack) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xarith_seq_chk.sv
module xarith_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic          op_done,
  input logic          illegal,
  input logic          rf_we,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic          fu_start
);

  a_r2_illegal_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(op_valid && op_ready));

  a_r2_illegal_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rf_we && !mem_req));

  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

  a_r1_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size != 2'b11));

  a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    fu_start |=> !fu_start);

  a_r10_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (op_ready && !op_done));

endmodule

bind xarith_seq xarith_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_done(op_done), .illegal(illegal), .rf_we(rf_we), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_size(mem_size),
  .fu_start(fu_start)
);

// File: tb/xarith_seq_bench.sv
`timescale 1ns/1ps
module xarith_seq_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          op_valid = 1'b0;
  logic [15:0]   op_code = 16'h0;
  logic          op_ready, op_done, illegal;
  logic [3:0]    rf_a_sel, rf_b_sel, rf_wsel;
  logic [DW-1:0] rf_a_data, rf_b_data, rf_wdata;
  logic          rf_we, mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size, fu_size;
  logic [DW-1:0] mem_wdata, mem_rdata, fu_src, fu_dst;
  logic          fu_start, fu_sub;
  logic          fu_done = 1'b0;
  logic [DW-1:0] fu_result = '0;

  xarith_seq #(.AW(AW), .DW(DW)) u_xarith_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_ready(op_ready), .op_done(op_done), .illegal(illegal),
    .rf_a_sel(rf_a_sel), .rf_a_data(rf_a_data), .rf_b_sel(rf_b_sel), .rf_b_data(rf_b_data),
    .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .fu_start(fu_start), .fu_sub(fu_sub), .fu_size(fu_size), .fu_src(fu_src),
    .fu_dst(fu_dst), .fu_done(fu_done), .fu_result(fu_result)
  );

  int total = 0;
  int bad = 0;

  // environment: register file
  logic [31:0] dreg [8];
  logic [31:0] areg [8];
  assign rf_a_data = rf_a_sel[3] ? areg[rf_a_sel[2:0]] : dreg[rf_a_sel[2:0]];
  assign rf_b_data = rf_b_sel[3] ? areg[rf_b_sel[2:0]] : dreg[rf_b_sel[2:0]];
  always @(posedge clk) if (rst_n && rf_we) begin
    if (rf_wsel[3]) areg[rf_wsel[2:0]] <= rf_wdata;
    else            dreg[rf_wsel[2:0]] <= rf_wdata;
  end

  // environment: memory with configurable ack delay
  logic [31:0] memarr [256];
  int ack_dly = 0;
  int wcnt = 0;
  assign mem_ack   = mem_req && (wcnt >= ack_dly);
  assign mem_rdata = memarr[mem_addr[7:0]];
  always @(posedge clk) begin
    if (mem_req && !mem_ack) wcnt <= wcnt + 1;
    else                     wcnt <= 0;
    if (mem_req && mem_ack && mem_we) memarr[mem_addr[7:0]] <= mem_wdata;
  end

  // environment: flag unit with configurable latency
  int fu_lat = 1;
  bit xflag = 1'b0;
  int fcnt = 0;
  logic fu_pend = 1'b0;
  logic [31:0] fres = '0;
  always @(posedge clk) begin
    fu_done <= 1'b0;
    if (fu_start) begin
      fcnt    <= fu_lat;
      fres    <= fu_sub ? (fu_dst - fu_src - {31'b0, xflag}) : (fu_dst + fu_src + {31'b0, xflag});
      fu_pend <= 1'b1;
    end else if (fu_pend) begin
      if (fcnt <= 1) begin
        fu_done   <= 1'b1;
        fu_result <= fres;
        fu_pend   <= 1'b0;
      end else fcnt <= fcnt - 1;
    end
  end

  // scoreboard
  typedef struct {
    int          kind;   // 0 reg write, 1 mem read, 2 mem write, 3 flag unit start
    logic [31:0] key;
    logic [31:0] d0;
    logic [31:0] d1;
    string       req;
  } item_t;
  item_t sbq[$];

  task automatic ck(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [31:0] key, input logic [31:0] d0,
                      input logic [31:0] d1, input string req);
    item_t it;
    it.kind = k; it.key = key; it.d0 = d0; it.d1 = d1; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic observe(input int k, input logic [31:0] key, input logic [31:0] d0, input logic [31:0] d1);
    item_t e;
    if (sbq.size() == 0) begin
      ck(1'b0, "R2 unexpected event", key, 32'hFFFF_FFFF);
    end else begin
      e = sbq.pop_front();
      ck(e.kind == k && e.key == key, {e.req, " kind/key"}, key, e.key);
      ck(e.d0 == d0 && e.d1 == d1, {e.req, " data"}, d0, e.d0);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rf_we) observe(0, {28'b0, rf_wsel}, rf_wdata, 32'h0);
    if (mem_req && mem_ack) observe(mem_we ? 2 : 1, mem_addr, mem_we ? mem_wdata : 32'h0, 32'h0);
    if (fu_start) observe(3, {29'b0, fu_sub, fu_size}, fu_src, fu_dst);
  end

  function automatic logic [31:0] msk(input logic [1:0] s);
    return (s == 2'b00) ? 32'hFF : (s == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] calc(input bit sub, input logic [31:0] d, input logic [31:0] s);
    return sub ? (d - s - {31'b0, xflag}) : (d + s + {31'b0, xflag});
  endfunction

  // driver: predicts the events of one legal opcode
  task automatic predict(input logic [15:0] op);
    logic [1:0] sz = op[7:6];
    logic [31:0] m = msk(sz);
    logic [31:0] n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    logic [2:0] s = op[2:0];
    logic [2:0] d = op[11:9];
    bit sub = (op[15:12] == 4'h9) || (op[15:12] == 4'h4);
    logic [31:0] sa, da, sv, dv, r;
    if (op[15:12] == 4'h4) begin
      sv = dreg[s] & m;
      r  = calc(1'b1, 32'h0, sv) & m;
      push(3, {29'b0, 1'b1, sz}, sv, 32'h0, "R7 negate operands");
      push(0, {28'b0, 1'b0, s}, (dreg[s] & ~m) | r, 32'h0, "R7 negate write");
    end else if (op[3]) begin
      sa = areg[s] - n;
      da = ((s == d) ? sa : areg[d]) - n;
      sv = memarr[sa[7:0]] & m;
      dv = memarr[da[7:0]] & m;
      r  = calc(sub, dv, sv) & m;
      push(0, {28'b0, 1'b1, s}, sa, 32'h0, "R3 source decrement");
      push(1, sa, 32'h0, 32'h0, "R3 source read");
      push(0, {28'b0, 1'b1, d}, da, 32'h0, (s == d) ? "R5 second decrement" : "R4 dest decrement");
      push(1, da, 32'h0, 32'h0, (s == d) ? "R5 dest read" : "R4 dest read");
      push(3, {29'b0, sub, sz}, sv, dv, "R8 operands");
      push(2, da, r, 32'h0, "R4 store");
    end else begin
      sv = dreg[s] & m;
      dv = dreg[d] & m;
      r  = calc(sub, dv, sv) & m;
      push(3, {29'b0, sub, sz}, sv, dv, "R1 R8 operands");
      push(0, {28'b0, 1'b0, d}, (dreg[d] & ~m) | r, 32'h0, "R6 partial write");
    end
  endtask

  task automatic wait_done();
    int w = 0;
    while (!op_done && w < 500) begin @(negedge clk); w++; end
    ck(op_done === 1'b1, "R10 done seen", {31'b0, op_done}, 32'h1);
    ck(sbq.size() == 0, "R10 all events seen", sbq.size(), 32'h0);
    @(negedge clk);
    ck(op_ready && !op_done, "R10 ready after done", {30'b0, op_ready, op_done}, 32'h2);
  endtask

  task automatic run_op(input logic [15:0] op, input bit expect_bad);
    if (!expect_bad) predict(op);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1;
    op_code  = op;
    @(negedge clk);
    op_valid = 1'b0;
    ck(illegal === expect_bad, "R2 illegal flag", {31'b0, illegal}, {31'b0, expect_bad});
    if (expect_bad) begin
      @(negedge clk);
      ck(op_ready && !illegal && sbq.size() == 0, "R2 pulse ends, still ready",
         {30'b0, op_ready, illegal}, 32'h2);
    end else wait_done();
  endtask

  task automatic run_pair(input logic [15:0] badop, input logic [15:0] goodop);
    predict(goodop);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1;
    op_code  = badop;
    @(negedge clk);
    ck(illegal && op_ready, "R2 illegal pulse with next accept", {30'b0, illegal, op_ready}, 32'h3);
    op_code = goodop;
    @(negedge clk);
    op_valid = 1'b0;
    ck(!illegal && !op_ready, "R2 second opcode taken", {30'b0, illegal, op_ready}, 32'h0);
    wait_done();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      ck(1'b0, "watchdog", cyc, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      dreg[i] = 32'h8765_4321 * (i + 3) ^ 32'h00F0_7F80;
      areg[i] = 32'h0000_1000 + 32'h20 * i + 32'h10;
    end
    for (int i = 0; i < 256; i++) memarr[i] = (i * 32'h0103_0507) ^ 32'hA500_00C3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ck(op_ready && !op_done && !illegal && !rf_we && !mem_req && !fu_start, "R10 reset state",
       {26'b0, op_ready, op_done, illegal, rf_we, mem_req, fu_start}, 32'h20);

    run_op(16'hD581, 1'b0);   // add long D1 -> D2
    xflag = 1'b1;
    run_op(16'h9903, 1'b0);   // sub byte D3 -> D4
    fu_lat = 3;
    run_op(16'hDB45, 1'b0);   // add word D5 -> D5
    run_op(16'h4006, 1'b0);   // negate byte D6
    xflag = 1'b0;
    run_op(16'h4047, 1'b0);   // negate word D7
    run_op(16'h4080, 1'b0);   // negate long D0
    ack_dly = 0; fu_lat = 1;
    run_op(16'hD589, 1'b0);   // add long -(A1),-(A2)
    ack_dly = 2; xflag = 1'b1;
    run_op(16'h914B, 1'b0);   // sub word -(A3),-(A0)
    ack_dly = 1;
    run_op(16'hD90C, 1'b0);   // add byte -(A4),-(A4)
    ack_dly = 3; fu_lat = 2;
    run_op(16'h9F8F, 1'b0);   // sub long -(A7),-(A7)
    run_op(16'hD1C0, 1'b1);   // size 11
    run_op(16'h40C0, 1'b1);   // negate with size 11
    run_op(16'h4010, 1'b1);   // negate with other mode (R7)
    run_op(16'h0000, 1'b1);   // unrecognised
    ack_dly = 0; fu_lat = 1;
    run_pair(16'hD5C1, 16'hD581);
    run_pair(16'h9DC9, 16'h9349);
    repeat (4) @(negedge clk);
    ck(sbq.size() == 0, "R2 no stray events", sbq.size(), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule